// File: doc/BRIEF.md
# Windowed Address Slot Translator

This block converts addresses issued on a 32-bit local bus into 48-bit system addresses through a fixed aperture of fifteen windows. Each window is 64 MB. The window that serves a request is set by where the address falls inside the aperture, so no tag search takes place. Every window has a descriptor that firmware writes through a small word-addressed register port. The descriptor holds a 22-bit frame number, which is the system address divided by 64 MB, and two copies of a type code. The system address sent out is the frame number joined to the low 26 bits of the local address.

The windows come in two groups. Windows 0 to 7 reach memory and accept only type codes 1 and 4. Windows 8 to 14 reach I/O and accept only codes 5 and 6. A type code outside a window's group is dropped. Firmware unmaps a window by writing zero to its descriptor words.

A lookup decodes the window combinationally and registers the result once. Each request gets one response, one cycle later, that reports either a hit with the system address and type, or a miss.

Top module: `aperture_xlate`

## Requirements
- R1: After reset every window is invalid, `rsp_valid` is 0, and a lookup of any address misses.
- R2: One cycle after an accepted request that hits a valid window, `rsp_valid` and `rsp_hit` are 1 and `rsp_miss` is 0. `rsp_sys_addr` equals {frame, req_addr[25:0]} and `rsp_type` is the type stored for that window.
- R3: A request below 0x04000000, or at or above 0x40000000, gives `rsp_miss`=1, `rsp_hit`=0, and zero address and type.
- R4: The window used for an address is (req_addr − 0x04000000) >> 26, so window 14 serves addresses up to 0x3FFFFFFF.
- R5: Configuration word address = {window[3:0], word[1:0]}. Word 0 is the frame, word 1 is control, word 2 is the type and word 3 is the type copy. A type or copy write is accepted only if the data is 0, or is 1 or 4 for windows 0–7, or is 5 or 6 for windows 8–14. Any other value leaves the stored code unchanged.
- R6: A window is valid only when its type and its copy are equal and nonzero. Writing zero to either word unmaps the window.
- R7: A descriptor write takes effect at the next clock edge. A lookup of the same window in the same cycle returns the old descriptor.
- R8: Writes to word 1, and writes to window index 15, change no translation.
- R9: `rsp_valid` is set exactly one cycle after `req_valid`. With no response, all response outputs are 0.
- R10: A frame write stores only data bits [21:0]. Higher bits are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor word write strobe |
| cfg_addr | input | 6 | Word address {window, word} |
| cfg_wdata | input | 32 | Descriptor write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Local bus address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | Outside aperture or window invalid |
| rsp_sys_addr | output | 48 | Translated system address |
| rsp_type | output | 3 | Type code of the serving window |

## Verification
The assertions assume that the inputs are known whenever reset is released. They also assume that at most one descriptor word changes per cycle, because the write port carries a single word. That single-word assumption is what allows a rejected type write to be checked as leaving every stored code stable. The bench changes every input only on the falling edge and issues at most one write per cycle. Its random stimulus draws type data from a mix of legal, illegal and zero codes, and draws addresses from the edges of the aperture, from inside windows, and from the full 32-bit range.

// File: rtl/apx_pkg.sv
package apx_pkg;

  localparam int CFG_DW = 32;

  localparam logic [CFG_DW-1:0] CODE_MEM_A = 32'd1;
  localparam logic [CFG_DW-1:0] CODE_MEM_B = 32'd4;
  localparam logic [CFG_DW-1:0] CODE_IO_A  = 32'd5;
  localparam logic [CFG_DW-1:0] CODE_IO_B  = 32'd6;

  typedef enum logic [1:0] {
    WD_FRAME = 2'd0,
    WD_CTRL  = 2'd1,
    WD_TYPE  = 2'd2,
    WD_COPY  = 2'd3
  } word_e;

  // Zero always passes so that firmware can unmap a window.
  function automatic logic type_code_ok(input logic io_group,
                                        input logic [CFG_DW-1:0] code);
    if (code == '0)
      return 1'b1;
    if (io_group)
      return (code == CODE_IO_A) || (code == CODE_IO_B);
    return (code == CODE_MEM_A) || (code == CODE_MEM_B);
  endfunction

endpackage

// File: rtl/apx_cfg_decode.sv
module apx_cfg_decode #(
  parameter int NUM_SLOTS = 15,
  parameter int MEM_SLOTS = 8,
  parameter int CFG_SW    = 4
) (
  input  logic                        cfg_we,
  input  logic [CFG_SW+1:0]           cfg_addr,
  input  logic [apx_pkg::CFG_DW-1:0]  cfg_wdata,
  output logic [NUM_SLOTS-1:0]        frame_we,
  output logic [NUM_SLOTS-1:0]        type_we,
  output logic [NUM_SLOTS-1:0]        copy_we,
  output logic [NUM_SLOTS-1:0]        type_reject
);
  import apx_pkg::*;

  logic [CFG_SW-1:0] slot_field;
  word_e             word_sel;

  assign slot_field = cfg_addr[CFG_SW+1:2];
  assign word_sel   = word_e'(cfg_addr[1:0]);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic addressed;
    logic code_ok;
    logic is_type_word;

    assign addressed    = cfg_we && (slot_field == CFG_SW'(s));
    assign code_ok      = type_code_ok(s >= MEM_SLOTS, cfg_wdata);
    assign is_type_word = (word_sel == WD_TYPE) || (word_sel == WD_COPY);

    assign frame_we[s]    = addressed && (word_sel == WD_FRAME);
    assign type_we[s]     = addressed && (word_sel == WD_TYPE) && code_ok;
    assign copy_we[s]     = addressed && (word_sel == WD_COPY) && code_ok;
    assign type_reject[s] = addressed && is_type_word && !code_ok;
  end

endmodule

// File: rtl/apx_slot_bank.sv
module apx_slot_bank #(
  parameter int NUM_SLOTS = 15,
  parameter int FRAME_W   = 22,
  parameter int TYPE_W    = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_SLOTS-1:0]               frame_we,
  input  logic [NUM_SLOTS-1:0]               type_we,
  input  logic [NUM_SLOTS-1:0]               copy_we,
  input  logic [FRAME_W-1:0]                 frame_wdata,
  input  logic [TYPE_W-1:0]                  type_wdata,
  output logic [NUM_SLOTS-1:0][FRAME_W-1:0]  frame_q,
  output logic [NUM_SLOTS-1:0][TYPE_W-1:0]   type_q,
  output logic [NUM_SLOTS-1:0][TYPE_W-1:0]   copy_q,
  output logic [NUM_SLOTS-1:0]               slot_valid
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frame_q[s] <= '0;
        type_q[s]  <= '0;
        copy_q[s]  <= '0;
      end else begin
        if (frame_we[s]) frame_q[s] <= frame_wdata;
        if (type_we[s])  type_q[s]  <= type_wdata;
        if (copy_we[s])  copy_q[s]  <= type_wdata;
      end
    end

    assign slot_valid[s] = (type_q[s] != '0) && (type_q[s] == copy_q[s]);
  end

endmodule

// File: rtl/apx_lookup.sv
module apx_lookup #(
  parameter int NUM_SLOTS  = 15,
  parameter int LOCAL_W    = 32,
  parameter int SYS_W      = 48,
  parameter int SLOT_SHIFT = 26,
  parameter int TYPE_W     = 3
) (
  input  logic [LOCAL_W-1:0]                       req_addr,
  input  logic [NUM_SLOTS-1:0][SYS_W-SLOT_SHIFT-1:0] frame_q,
  input  logic [NUM_SLOTS-1:0][TYPE_W-1:0]         type_q,
  input  logic [NUM_SLOTS-1:0]                     slot_valid,
  output logic [NUM_SLOTS-1:0]                     slot_sel,
  output logic                                     hit,
  output logic [SYS_W-1:0]                         sys_addr,
  output logic [TYPE_W-1:0]                        typ
);
  localparam int FRAME_W = SYS_W - SLOT_SHIFT;
  localparam int FIELD_W = LOCAL_W - SLOT_SHIFT;

  function automatic logic [SYS_W-1:0] compose(input logic [FRAME_W-1:0] frame,
                                               input logic [LOCAL_W-1:0] addr);
    return {frame, addr[SLOT_SHIFT-1:0]};
  endfunction

  logic [FIELD_W-1:0] field;
  logic [FRAME_W-1:0] sel_frame;
  logic [TYPE_W-1:0]  sel_type;
  logic               sel_valid;

  assign field = req_addr[LOCAL_W-1:SLOT_SHIFT];

  // Window n sits one window-size above the base of the local map.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_sel
    assign slot_sel[s] = (field == FIELD_W'(s + 1));
  end

  always_comb begin
    sel_frame = '0;
    sel_type  = '0;
    sel_valid = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slot_sel[s]) begin
        sel_frame = frame_q[s];
        sel_type  = type_q[s];
        sel_valid = slot_valid[s];
      end
    end
  end

  assign hit      = sel_valid;
  assign sys_addr = compose(sel_frame, req_addr);
  assign typ      = sel_type;

endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate #(
  parameter int NUM_SLOTS  = 15,
  parameter int MEM_SLOTS  = 8,
  parameter int LOCAL_W    = 32,
  parameter int SYS_W      = 48,
  parameter int SLOT_SHIFT = 26,
  parameter int TYPE_W     = 3,
  parameter int CFG_AW     = $clog2(NUM_SLOTS) + 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  logic [apx_pkg::CFG_DW-1:0]  cfg_wdata,
  input  logic                        req_valid,
  input  logic [LOCAL_W-1:0]          req_addr,
  output logic                        rsp_valid,
  output logic                        rsp_hit,
  output logic                        rsp_miss,
  output logic [SYS_W-1:0]            rsp_sys_addr,
  output logic [TYPE_W-1:0]           rsp_type
);
  localparam int FRAME_W = SYS_W - SLOT_SHIFT;
  localparam int CFG_SW  = CFG_AW - 2;

  logic [NUM_SLOTS-1:0]              frame_we;
  logic [NUM_SLOTS-1:0]              type_we;
  logic [NUM_SLOTS-1:0]              copy_we;
  logic [NUM_SLOTS-1:0]              type_reject;
  logic [NUM_SLOTS-1:0][FRAME_W-1:0] frame_q;
  logic [NUM_SLOTS-1:0][TYPE_W-1:0]  type_q;
  logic [NUM_SLOTS-1:0][TYPE_W-1:0]  copy_q;
  logic [NUM_SLOTS-1:0]              slot_valid;
  logic [NUM_SLOTS-1:0]              slot_sel;
  logic                              lk_hit;
  logic [SYS_W-1:0]                  lk_sys_addr;
  logic [TYPE_W-1:0]                 lk_type;

  apx_cfg_decode #(
    .NUM_SLOTS (NUM_SLOTS),
    .MEM_SLOTS (MEM_SLOTS),
    .CFG_SW    (CFG_SW)
  ) u_decode (
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .frame_we    (frame_we),
    .type_we     (type_we),
    .copy_we     (copy_we),
    .type_reject (type_reject)
  );

  apx_slot_bank #(
    .NUM_SLOTS (NUM_SLOTS),
    .FRAME_W   (FRAME_W),
    .TYPE_W    (TYPE_W)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_we    (frame_we),
    .type_we     (type_we),
    .copy_we     (copy_we),
    .frame_wdata (cfg_wdata[FRAME_W-1:0]),
    .type_wdata  (cfg_wdata[TYPE_W-1:0]),
    .frame_q     (frame_q),
    .type_q      (type_q),
    .copy_q      (copy_q),
    .slot_valid  (slot_valid)
  );

  apx_lookup #(
    .NUM_SLOTS  (NUM_SLOTS),
    .LOCAL_W    (LOCAL_W),
    .SYS_W      (SYS_W),
    .SLOT_SHIFT (SLOT_SHIFT),
    .TYPE_W     (TYPE_W)
  ) u_lookup (
    .req_addr   (req_addr),
    .frame_q    (frame_q),
    .type_q     (type_q),
    .slot_valid (slot_valid),
    .slot_sel   (slot_sel),
    .hit        (lk_hit),
    .sys_addr   (lk_sys_addr),
    .typ        (lk_type)
  );

  // Single registered response stage; the lookup reads descriptors as
  // they stand before this edge's write lands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_sys_addr <= '0;
      rsp_type     <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_hit      <= req_valid && lk_hit;
      rsp_miss     <= req_valid && !lk_hit;
      rsp_sys_addr <= (req_valid && lk_hit) ? lk_sys_addr : '0;
      rsp_type     <= (req_valid && lk_hit) ? lk_type : '0;
    end
  end

endmodule

// File: rtl/apx_checker.sv
module apx_checker #(
  parameter int NUM_SLOTS  = 15,
  parameter int MEM_SLOTS  = 8,
  parameter int LOCAL_W    = 32,
  parameter int SYS_W      = 48,
  parameter int SLOT_SHIFT = 26,
  parameter int TYPE_W     = 3
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              req_valid,
  input logic [LOCAL_W-1:0]                req_addr,
  input logic                              rsp_valid,
  input logic                              rsp_hit,
  input logic                              rsp_miss,
  input logic [SYS_W-1:0]                  rsp_sys_addr,
  input logic [TYPE_W-1:0]                 rsp_type,
  input logic [NUM_SLOTS-1:0]              slot_sel,
  input logic [NUM_SLOTS-1:0]              slot_valid,
  input logic [NUM_SLOTS-1:0]              type_reject,
  input logic [NUM_SLOTS-1:0][TYPE_W-1:0]  type_q,
  input logic [NUM_SLOTS-1:0][TYPE_W-1:0]  copy_q
);
  localparam int FIELD_W = LOCAL_W - SLOT_SHIFT;

  logic [FIELD_W-1:0] req_field;
  logic               req_in_window;
  logic               req_mem_group;

  assign req_field     = req_addr[LOCAL_W-1:SLOT_SHIFT];
  assign req_in_window = (req_field != '0) && (req_field <= FIELD_W'(NUM_SLOTS));
  assign req_mem_group = req_field <= FIELD_W'(MEM_SLOTS);

  a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss &&
                    rsp_sys_addr == '0 && rsp_type == '0));

  a_r2_hit_or_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_miss));

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit ||
      rsp_sys_addr[SLOT_SHIFT-1:0] == $past(req_addr[SLOT_SHIFT-1:0])));

  a_r3_outside_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_in_window) |=> (rsp_miss && rsp_sys_addr == '0));

  a_r4_one_window: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_sel) && ((slot_sel != '0) == req_in_window));

  a_r5_mem_group_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_in_window && req_mem_group) |=>
      (!rsp_hit || rsp_type == TYPE_W'(1) || rsp_type == TYPE_W'(4)));

  a_r5_io_group_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_in_window && !req_mem_group) |=>
      (!rsp_hit || rsp_type == TYPE_W'(5) || rsp_type == TYPE_W'(6)));

  a_r5_reject_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (type_reject != '0) |=> ($stable(type_q) && $stable(copy_q)));

  a_r6_invalid_window_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (slot_sel & slot_valid) == '0) |=> rsp_miss);

endmodule

bind aperture_xlate apx_checker #(
  .NUM_SLOTS  (NUM_SLOTS),
  .MEM_SLOTS  (MEM_SLOTS),
  .LOCAL_W    (LOCAL_W),
  .SYS_W      (SYS_W),
  .SLOT_SHIFT (SLOT_SHIFT),
  .TYPE_W     (TYPE_W)
) u_apx_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_addr     (req_addr),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_miss     (rsp_miss),
  .rsp_sys_addr (rsp_sys_addr),
  .rsp_type     (rsp_type),
  .slot_sel     (slot_sel),
  .slot_valid   (slot_valid),
  .type_reject  (type_reject),
  .type_q       (type_q),
  .copy_q       (copy_q)
);

// File: tb/aperture_xlate_tb.sv
module aperture_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_hit;
  logic        rsp_miss;
  logic [47:0] rsp_sys_addr;
  logic [2:0]  rsp_type;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [21:0] m_frame [15];
  logic [2:0]  m_type  [15];
  logic [2:0]  m_copy  [15];

  always #5 clk = ~clk;

  aperture_xlate dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss),
    .rsp_sys_addr (rsp_sys_addr),
    .rsp_type     (rsp_type)
  );

  function automatic bit code_legal(int win, logic [31:0] d);
    if (d == 32'd0) return 1'b1;
    if (win < 8) return (d == 32'd1) || (d == 32'd4);
    return (d == 32'd5) || (d == 32'd6);
  endfunction

  function automatic void model_write(logic [5:0] wa, logic [31:0] wd);
    int win = int'(wa[5:2]);
    if (win >= 15) return;
    case (wa[1:0])
      2'd0: m_frame[win] = wd[21:0];
      2'd2: if (code_legal(win, wd)) m_type[win] = wd[2:0];
      2'd3: if (code_legal(win, wd)) m_copy[win] = wd[2:0];
      default: ;
    endcase
  endfunction

  // Window = (addr - 64MB) / 64MB; offset kept below the window size.
  function automatic void predict(logic [31:0] ra, output bit hit,
                                  output logic [47:0] sys, output logic [2:0] ty);
    int unsigned above = ra - 32'h0400_0000;
    int win = int'(above / 32'h0400_0000);
    hit = 1'b0; sys = '0; ty = '0;
    if (ra >= 32'h0400_0000 && ra < 32'h4000_0000) begin
      if (m_type[win] != 3'd0 && m_type[win] == m_copy[win]) begin
        hit = 1'b1;
        sys = (48'(m_frame[win]) * 48'h400_0000) + 48'(ra % 32'h0400_0000);
        ty  = m_type[win];
      end
    end
  endfunction

  function automatic logic [31:0] win_addr(int win, logic [25:0] off);
    return 32'h0400_0000 * (win + 1) + 32'(off);
  endfunction

  // Called on a falling edge; drives one cycle and checks its response.
  task automatic step(input bit we, input logic [5:0] wa, input logic [31:0] wd,
                      input bit rv, input logic [31:0] ra, input string tag);
    bit          eh;
    logic [47:0] es;
    logic [2:0]  et;
    cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
    req_valid = rv; req_addr = ra;
    predict(ra, eh, es, et);
    if (we) model_write(wa, wd);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    checks++;
    if (rv) begin
      if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_miss !== !eh ||
          rsp_sys_addr !== es || rsp_type !== et) begin
        errors++;
        $display("FAIL %s addr=%h: got v=%b h=%b m=%b sys=%h t=%0d exp v=1 h=%b m=%b sys=%h t=%0d",
                 tag, ra, rsp_valid, rsp_hit, rsp_miss, rsp_sys_addr, rsp_type,
                 eh, !eh, es, et);
      end
    end else begin
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_miss !== 1'b0 ||
          rsp_sys_addr !== '0 || rsp_type !== '0) begin
        errors++;
        $display("FAIL %s idle: got v=%b h=%b m=%b sys=%h t=%0d exp all zero",
                 tag, rsp_valid, rsp_hit, rsp_miss, rsp_sys_addr, rsp_type);
      end
    end
  endtask

  task automatic wr(input logic [5:0] wa, input logic [31:0] wd, input string tag);
    step(1'b1, wa, wd, 1'b0, 32'h0, tag);
  endtask

  task automatic look(input logic [31:0] ra, input string tag);
    step(1'b0, 6'd0, 32'd0, 1'b1, ra, tag);
  endtask

  task automatic map(input int win, input logic [31:0] frame, input logic [31:0] ty);
    wr(6'({4'(win), 2'd0}), frame, "R5");
    wr(6'({4'(win), 2'd2}), ty, "R5");
    wr(6'({4'(win), 2'd3}), ty, "R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_out;
    for (int i = 0; i < 15; i++) begin
      m_frame[i] = '0; m_type[i] = '0; m_copy[i] = '0;
    end
    seed_out = $urandom(32'h5A17);

    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got rsp_valid=%b exp 0", rsp_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every window invalid out of reset
    for (int w = 0; w < 15; w++) look(win_addr(w, 26'h10), "R1");

    // R2/R4: I/O window 8 reaching a port in high system space
    map(8, 32'h003F_FF7F, 32'd6);
    look(32'h2400_0080, "R2");
    // R2: memory window 0
    map(0, 32'h0000_0123, 32'd1);
    look(32'h0400_1234, "R2");
    look(32'h07FF_FFFF, "R4");

    // R5: I/O code into memory window is dropped, legal code kept
    wr(6'({4'd0, 2'd2}), 32'd5, "R5");
    look(32'h0400_0000, "R5");
    wr(6'({4'd0, 2'd2}), 32'd4, "R5");
    look(32'h0400_0000, "R6");
    wr(6'({4'd0, 2'd3}), 32'd4, "R5");
    look(32'h0400_0000, "R5");
    wr(6'({4'd9, 2'd2}), 32'd1, "R5");
    wr(6'({4'd9, 2'd2}), 32'h0000_0105, "R5");
    look(win_addr(9, 26'h0), "R5");

    // R3/R4: aperture edges
    map(14, 32'h0015_5555, 32'd5);
    look(32'h3FFF_FFFF, "R4");
    look(32'h4000_0000, "R3");
    look(32'h03FF_FFFF, "R3");
    look(32'hFFFF_FFFF, "R3");
    look(32'h0000_0000, "R3");

    // R6: mismatched copy, then unmap by zero
    map(3, 32'h0000_0AAA, 32'd1);
    wr(6'({4'd3, 2'd3}), 32'd4, "R6");
    look(win_addr(3, 26'h3_0000), "R6");
    wr(6'({4'd8, 2'd0}), 32'd0, "R6");
    wr(6'({4'd8, 2'd2}), 32'd0, "R6");
    wr(6'({4'd8, 2'd3}), 32'd0, "R6");
    look(32'h2400_0080, "R6");

    // R7: write and lookup of the same window together see the old frame
    step(1'b1, 6'({4'd0, 2'd0}), 32'h0000_0777, 1'b1, 32'h0400_0040, "R7");
    look(32'h0400_0040, "R7");

    // R8: control word and window 15 writes leave translations unchanged
    wr(6'({4'd0, 2'd1}), 32'hFFFF_FFFF, "R8");
    wr(6'({4'd15, 2'd0}), 32'h0000_0001, "R8");
    wr(6'({4'd15, 2'd2}), 32'd6, "R8");
    look(32'h0400_0040, "R8");
    look(32'h3FFF_0000, "R8");

    // R10: frame word upper bits discarded
    wr(6'({4'd0, 2'd0}), 32'hFFC0_0ABC, "R10");
    look(32'h0400_0001, "R10");

    // R9: no request, no response
    step(1'b0, 6'd0, 32'd0, 1'b0, 32'h0400_0000, "R9");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      bit          we = ($urandom % 2) == 0;
      bit          rv = ($urandom % 4) != 0;
      logic [5:0]  wa = 6'($urandom);
      logic [31:0] wd;
      logic [31:0] ra;
      case ($urandom % 8)
        0: wd = 32'd0;
        1: wd = 32'd1;
        2: wd = 32'd4;
        3: wd = 32'd5;
        4: wd = 32'd6;
        5: wd = 32'($urandom % 8);
        default: wd = $urandom;
      endcase
      case ($urandom % 4)
        0: ra = $urandom;
        1: ra = ($urandom % 2) ? 32'h03FF_FFFF : 32'h4000_0000;
        default: ra = win_addr(int'($urandom % 15), 26'($urandom));
      endcase
      step(we, wa, wd, rv, ra, rv ? "R2" : "R9");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule